// File: doc/BRIEF.md
# Grouped Crosspoint Programming Sequencer

This block programs a chain of serially loaded analog crosspoint switches from a logical routing map. Each device in the chain has 16 physical outputs. Each output takes a 5-bit control word: one enable bit and a 4-bit input select. A video channel may need one, two or three physical switch channels, as with single-ended, differential or luma/chroma, and component formats. The block therefore treats the map as logical routes and expands each route into a group of adjacent physical outputs and inputs.

After a start pulse, the block walks every device and every physical output. It computes each control word as it is needed and shifts the words for the whole chain out as one stream. It then pulses the active-low update strobe once, so the new configuration takes effect across the array at the same moment. The serial clock runs at half the system clock and never stops. An active-low chip enable marks the time during which the chain accepts bits.

The routing map and the mode must stay stable from start until done.

Top module: `xpt_group_seq`

## Requirements
- R1: A transfer shifts exactly N_DEV*80 bits. A bit counts when it is presented while the serial clock is high, chip enable is low and update is high.
- R2: The stream order is fixed. The last device in the chain goes first, then the others down to device 0. Within a device, output 15 comes first and output 0 last. Each word starts with the enable bit, followed by the select bits MSB first. In the map, logical output j of device d uses enable bit d*16+j and select bits [(d*16+j)*4 +: 4].
- R3: mode 1 selects pairs. Logical output k with select s drives physical outputs 2k+o (o = 0, 1) with enable 1 and select 2s+o. Logical outputs 0 to 7 are used.
- R4: mode 2 selects triples. Logical output k with select s drives physical outputs 3k+o (o = 0, 1, 2) with enable 1 and select 3s+o. Logical outputs 0 to 4 are used.
- R5: A physical output that no complete group covers (output 15 in mode 2) is sent as word 00000.
- R6: A logical output is sent as 00000 on all of its physical outputs in two cases: its enable is 0, or its select is not below the logical channel count (16, 8 or 5).
- R7: The serial clock toggles on every system clock cycle from reset onward. Serial data changes only on the cycles in which the serial clock rises.
- R8: Chip enable is low continuously from the first bit through the end of the update pulse, for 2*N_DEV*80+2 system cycles. It is high at all other times.
- R9: Update goes low only after the last bit has been shifted. It stays low for exactly one serial clock period (2 system cycles).
- R10: Done is high for exactly one cycle, in the cycle in which update returns high. Busy is low in that cycle.
- R11: A start pulse that arrives while busy is high is ignored. No second transfer follows it.
- R12: During reset and after it, the outputs are: serial data 0, chip enable high, update high, busy 0, done 0.
- R13: mode 0 and mode 3 both map logical output j directly to physical output j, with the select taken unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to program the chain |
| mode_i | input | 2 | Group size: 0 or 3 single, 1 pair, 2 triple |
| map_en_i | input | N_DEV*16 | Logical route enables, device-major |
| map_sel_i | input | N_DEV*64 | Logical input selects, 4 bits per route |
| sclk_o | output | 1 | Continuous serial clock, half the system rate |
| sdata_o | output | 1 | Serial data, changes on the serial clock rising edge |
| ce_n_o | output | 1 | Active-low chip enable for the chain |
| upd_n_o | output | 1 | Active-low update strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong word address or group decode has a visible effect at the ports. It puts a wrong bit into the captured stream at a known position, within one serial clock period of the bit's slot, and the bench reports the first mismatching device, output and word. A miscounted position counter changes the number of bits captured before update falls, or makes update fall too early. Either error is seen at the end of the transfer at the latest. A stuck or wrong control state shows up within one or two cycles: the serial clock stops toggling, chip enable stays low, or done pulses without the update strobe.

// File: rtl/xpt_seq_pkg.sv
// Package: shared constants and types for the grouped crosspoint sequencer.
// Assumes every device has 16 outputs, each with a 5-bit word {enable, select[3:0]}.
package xpt_seq_pkg;
    localparam int OUTS_PER_DEV = 16;
    localparam int SEL_W        = 4;
    localparam int WORD_W       = SEL_W + 1;
    localparam int BITS_PER_DEV = OUTS_PER_DEV * WORD_W;

    localparam logic [1:0] MODE_SINGLE = 2'd0;
    localparam logic [1:0] MODE_PAIR   = 2'd1;
    localparam logic [1:0] MODE_TRIPLE = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_SHIFT = 2'd2,
        ST_UPD   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/xpt_sclk_gen.sv
// Serial clock generator: divides the system clock by two and never pauses.
// Assumes consumers act on the cycle marked by rise_o, in which sclk_o goes high.
module xpt_sclk_gen (
    input  logic clk,
    input  logic rst_n,
    output logic sclk_o,
    output logic rise_o
);
    logic phase_q;

    // Toggle the phase every cycle; reset holds it low.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    assign sclk_o = phase_q;
    assign rise_o = ~phase_q;
endmodule

// File: rtl/xpt_word_map.sv
// Word mapper: computes the control word of one physical output of one device
// from the logical map and the group mode. Purely combinational.
// Assumes the map is stable while it is addressed.
module xpt_word_map
    import xpt_seq_pkg::*;
#(
    parameter int N_DEV = 4,
    localparam int DEV_W = (N_DEV > 1) ? $clog2(N_DEV) : 1,
    localparam int IDX_W = DEV_W + 4
) (
    input  logic [N_DEV*OUTS_PER_DEV-1:0]       map_en_i,
    input  logic [N_DEV*OUTS_PER_DEV*SEL_W-1:0] map_sel_i,
    input  logic [1:0]                          mode_i,
    input  logic [DEV_W-1:0]                    dev_i,
    input  logic [3:0]                          pout_i,
    output logic [WORD_W-1:0]                   word_o
);
    logic [3:0]       lin, off, gsz, sel_raw, phys;
    logic [4:0]       nlog;
    logic [IDX_W-1:0] idx;
    logic             en_raw, valid;

    // Split the physical output into logical route and member offset.
    always_comb begin
        case (mode_i)
            MODE_PAIR: begin
                lin = {1'b0, pout_i[3:1]};
                gsz = 4'd2;
                nlog = 5'd8;
            end
            MODE_TRIPLE: begin
                lin = pout_i / 4'd3;
                gsz = 4'd3;
                nlog = 5'd5;
            end
            default: begin
                lin = pout_i;
                gsz = 4'd1;
                nlog = 5'd16;
            end
        endcase
        off = pout_i - lin * gsz;
    end

    // Fetch the route and build the word; out-of-range or disabled gives zero.
    always_comb begin
        idx     = {dev_i, lin};
        en_raw  = map_en_i[idx];
        sel_raw = map_sel_i[{idx, 2'b00} +: SEL_W];
        valid   = en_raw && ({1'b0, lin} < nlog) && ({1'b0, sel_raw} < nlog);
        phys    = sel_raw * gsz + off;
        word_o  = valid ? {1'b1, phys} : '0;
    end
endmodule

// File: rtl/xpt_shift_seq.sv
// Shift sequencer: walks devices from last to first, outputs from 15 to 0 and
// word bits from enable to select LSB, presents each bit on a serial clock
// rising edge, then issues one update period and a done pulse.
// Assumes rise_i is high every other cycle.
module xpt_shift_seq
    import xpt_seq_pkg::*;
#(
    parameter int N_DEV = 4,
    localparam int DEV_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rise_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [DEV_W-1:0]  dev_o,
    output logic [3:0]        pout_o,
    output logic              sdata_o,
    output logic              ce_n_o,
    output logic              upd_n_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [DEV_W-1:0] DEV_LAST = DEV_W'(N_DEV - 1);

    seq_state_t state_q;
    logic [DEV_W-1:0] dev_q;
    logic [3:0]       out_q;
    logic [2:0]       bit_q;
    logic             sent_all_q;
    logic             cur_bit, at_last;

    // Select the word bit the counters point at: enable first, then select MSB first.
    always_comb begin
        cur_bit = word_i[3'd4 - bit_q];
        at_last = (dev_q == '0) && (out_q == 4'd0) && (bit_q == 3'd4);
    end

    // Control state, position counters and registered pin outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            dev_q      <= DEV_LAST;
            out_q      <= 4'd15;
            bit_q      <= 3'd0;
            sent_all_q <= 1'b0;
            sdata_o    <= 1'b0;
            ce_n_o     <= 1'b1;
            upd_n_o    <= 1'b1;
            done_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    dev_q      <= DEV_LAST;
                    out_q      <= 4'd15;
                    bit_q      <= 3'd0;
                    sent_all_q <= 1'b0;
                    if (start_i) state_q <= ST_ARM;
                end
                ST_ARM, ST_SHIFT: begin
                    if (rise_i) begin
                        if (sent_all_q) begin
                            upd_n_o <= 1'b0;
                            state_q <= ST_UPD;
                        end else begin
                            state_q    <= ST_SHIFT;
                            ce_n_o     <= 1'b0;
                            sdata_o    <= cur_bit;
                            sent_all_q <= at_last;
                            if (bit_q == 3'd4) begin
                                bit_q <= 3'd0;
                                out_q <= out_q - 4'd1;
                                if (out_q == 4'd0) dev_q <= dev_q - 1'b1;
                            end else begin
                                bit_q <= bit_q + 3'd1;
                            end
                        end
                    end
                end
                default: begin
                    if (rise_i) begin
                        upd_n_o <= 1'b1;
                        ce_n_o  <= 1'b1;
                        done_o  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign dev_o  = dev_q;
    assign pout_o = out_q;
    assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/xpt_group_seq.sv
// Top: grouped crosspoint programming sequencer. Joins the serial clock
// generator, the word mapper and the shift sequencer.
// Assumes map and mode are held stable from start until done.
module xpt_group_seq
    import xpt_seq_pkg::*;
#(
    parameter int N_DEV = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic [1:0]                        mode_i,
    input  logic [N_DEV*OUTS_PER_DEV-1:0]     map_en_i,
    input  logic [N_DEV*OUTS_PER_DEV*SEL_W-1:0] map_sel_i,
    output logic                              sclk_o,
    output logic                              sdata_o,
    output logic                              ce_n_o,
    output logic                              upd_n_o,
    output logic                              busy_o,
    output logic                              done_o
);
    localparam int DEV_W = (N_DEV > 1) ? $clog2(N_DEV) : 1;

    logic              rise;
    logic [DEV_W-1:0]  dev;
    logic [3:0]        pout;
    logic [WORD_W-1:0] word;

    xpt_sclk_gen u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_o (sclk_o),
        .rise_o (rise)
    );

    xpt_word_map #(.N_DEV(N_DEV)) u_map (
        .map_en_i  (map_en_i),
        .map_sel_i (map_sel_i),
        .mode_i    (mode_i),
        .dev_i     (dev),
        .pout_i    (pout),
        .word_o    (word)
    );

    xpt_shift_seq #(.N_DEV(N_DEV)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .rise_i  (rise),
        .word_i  (word),
        .dev_o   (dev),
        .pout_o  (pout),
        .sdata_o (sdata_o),
        .ce_n_o  (ce_n_o),
        .upd_n_o (upd_n_o),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );
endmodule

// File: rtl/xpt_group_seq_chk.sv
// Checker: temporal rules at the pins of the sequencer, attached by bind.
module xpt_group_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk_o,
    input logic sdata_o,
    input logic ce_n_o,
    input logic upd_n_o,
    input logic busy_o,
    input logic done_o
);
    AST_SCLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sclk_o != $past(sclk_o)));                       // R7
    AST_DATA_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_o) |-> $rose(sclk_o));                        // R7
    AST_CE_DURING_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_n_o |-> !ce_n_o);                                      // R8
    AST_UPD_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upd_n_o) |=> (!upd_n_o ##1 upd_n_o));                  // R9
    AST_DONE_ON_UPD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($rose(upd_n_o) && !busy_o));                     // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                        // R10
endmodule

bind xpt_group_seq xpt_group_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_o  (sclk_o),
    .sdata_o (sdata_o),
    .ce_n_o  (ce_n_o),
    .upd_n_o (upd_n_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/xpt_group_seq_tb.sv
module xpt_group_seq_tb;
    localparam int NDEV = 4;
    localparam int TOT  = NDEV * 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic [NDEV*16-1:0] map_en_i = '0;
    logic [NDEV*64-1:0] map_sel_i = '0;
    logic sclk_o, sdata_o, ce_n_o, upd_n_o, busy_o, done_o;

    int n_chk = 0;
    int n_fail = 0;
    logic stream [TOT];

    always #2 clk = ~clk;

    xpt_group_seq #(.N_DEV(NDEV)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .map_en_i(map_en_i), .map_sel_i(map_sel_i), .sclk_o(sclk_o),
        .sdata_o(sdata_o), .ce_n_o(ce_n_o), .upd_n_o(upd_n_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected word of physical output p of device d, built route by route.
    function automatic logic [4:0] exp_word(input int d, input int p, input logic [1:0] md);
        int g, nl;
        logic [4:0] w;
        g  = (md == 2'd1) ? 2 : (md == 2'd2) ? 3 : 1;
        nl = 16 / g;
        w  = 5'b0;
        for (int j = 0; j < nl; j++) begin
            for (int o = 0; o < g; o++) begin
                int s;
                s = int'(map_sel_i[(d*16+j)*4 +: 4]);
                if (j*g + o == p && map_en_i[d*16+j] && s < nl)
                    w = {1'b1, 4'(s*g + o)};
            end
        end
        return w;
    endfunction

    task automatic run_xfer(input logic [1:0] md, input string tag, input bit poke_busy);
        int nb, upd_low, ce_low, done_cnt, bits_at_upd, sclk_bad, cyc, mism, extra_ce;
        logic prev_sclk, prev_upd;
        bit finished;
        nb = 0; upd_low = 0; ce_low = 0; done_cnt = 0; bits_at_upd = -1;
        sclk_bad = 0; mism = 0; extra_ce = 0; finished = 0;
        @(negedge clk);
        mode_i = md;
        start_i = 1'b1;
        prev_sclk = sclk_o;
        prev_upd = upd_n_o;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (!finished && cyc < 2*TOT + 40) begin
            if (sclk_o == prev_sclk) sclk_bad++;
            prev_sclk = sclk_o;
            if (sclk_o && !ce_n_o && upd_n_o && nb < TOT) begin
                stream[nb] = sdata_o;
                nb++;
            end
            if (!ce_n_o) ce_low++;
            if (!upd_n_o) upd_low++;
            if (!upd_n_o && prev_upd) bits_at_upd = nb;
            prev_upd = upd_n_o;
            if (done_o) begin
                done_cnt++;
                finished = 1;
                chk(upd_n_o && !busy_o, {tag, " R10 upd high, busy low at done"},
                    int'({upd_n_o, busy_o}), 2);
            end
            start_i = (poke_busy && cyc == 50);
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        chk(finished, {tag, " R10 done seen"}, int'(finished), 1);
        chk(!done_o, {tag, " R10 done lasts one cycle"}, int'(done_o), 0);
        for (int k = 0; k < 12; k++) begin
            if (!ce_n_o || busy_o || done_o) extra_ce++;
            @(negedge clk);
        end
        chk(extra_ce == 0, poke_busy ? {tag, " R11 no second transfer"} : {tag, " R8 idle after done"},
            extra_ce, 0);
        chk(nb == TOT, {tag, " R1 bit count"}, nb, TOT);
        chk(bits_at_upd == TOT, {tag, " R9 update after last bit"}, bits_at_upd, TOT);
        chk(upd_low == 2, {tag, " R9 update width"}, upd_low, 2);
        chk(ce_low == 2*TOT + 2, {tag, " R8 chip enable span"}, ce_low, 2*TOT + 2);
        chk(sclk_bad == 0, {tag, " R7 serial clock continuous"}, sclk_bad, 0);
        // R2 ordering with the grouping rules of the mode under test
        begin
            int fa, fe;
            fa = 0; fe = 0;
            for (int d = 0; d < NDEV; d++) begin
                for (int p = 0; p < 16; p++) begin
                    logic [4:0] e, a;
                    e = exp_word(d, p, md);
                    for (int b = 0; b < 5; b++)
                        a[4-b] = stream[(NDEV-1-d)*80 + (15-p)*5 + b];
                    if (a !== e && mism == 0) begin
                        fa = int'(a); fe = int'(e);
                        $display("  first mismatch device %0d output %0d", d, p);
                    end
                    if (a !== e) mism++;
                end
            end
            chk(mism == 0, {tag, " R2 stream words"}, fa, fe);
        end
    endtask

    task automatic rand_map();
        for (int i = 0; i < NDEV*16; i++) begin
            map_en_i[i] = ($urandom_range(0, 3) != 0);
            map_sel_i[i*4 +: 4] = 4'($urandom_range(0, 15));
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(sdata_o == 0 && ce_n_o && upd_n_o && !busy_o && !done_o, "R12 outputs in reset",
            int'({sdata_o, ce_n_o, upd_n_o, busy_o, done_o}), 8'b01100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sdata_o == 0 && ce_n_o && upd_n_o && !busy_o && !done_o, "R12 outputs after reset",
            int'({sdata_o, ce_n_o, upd_n_o, busy_o, done_o}), 8'b01100);

        rand_map(); run_xfer(2'd0, "R13 single mode 0", 0);
        rand_map(); run_xfer(2'd1, "R3 R6 pairs", 0);
        rand_map(); run_xfer(2'd2, "R4 R5 R6 triples", 0);
        rand_map(); run_xfer(2'd3, "R13 mode 3 as single", 1);

        // Directed: all routes enabled at the top legal select, pairs
        map_en_i = '1;
        for (int i = 0; i < NDEV*16; i++) map_sel_i[i*4 +: 4] = 4'd7;
        run_xfer(2'd1, "R3 pairs select 7", 0);
        // Directed: select 5 in triples is out of range, all words zero
        for (int i = 0; i < NDEV*16; i++) map_sel_i[i*4 +: 4] = 4'd5;
        run_xfer(2'd2, "R5 R6 triples select 5", 0);
        // Directed: select 4 in triples, highest legal group
        for (int i = 0; i < NDEV*16; i++) map_sel_i[i*4 +: 4] = 4'd4;
        run_xfer(2'd2, "R4 triples select 4", 0);

        for (int r = 0; r < 4; r++) begin
            rand_map();
            run_xfer(2'($urandom_range(0, 3)), "R2 random", 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule